// File: doc/BRIEF.md
# Four-Lane Rotation-Based Sine Synthesizer

This block is a direct digital synthesizer that turns a frequency tuning word into a stream of signed sine samples, four of them on every clock. A 24-bit phase accumulator moves forward by four tuning steps per clock. Four parallel adders derive the phases of the four lanes from it. Each lane folds its phase into the first quadrant. It then runs the folded angle through a pipelined coordinate-rotation engine that needs no stored sine table. At the end it restores the sign, and swaps sine for cosine where the quadrant requires it.

Lane 0 holds the earliest sample in time and lane 3 the latest. An external serializer that sends lanes 0..3 in order, one clock after another, therefore sees a phase-continuous waveform at four times the fabric clock rate. The tuning word sits in a holding register that is loaded by a strobe. An enable gates whether the accumulator advances and whether a sample set enters the pipeline.

Top module: `dds_quad_cordic`

## Requirements
- R1: A synchronous reset (`srst` high at a rising edge) clears the accumulator to phase 0, clears the held tuning word to 0, drives every valid bit low and drives all samples to 0.
- R2: For each enabled clock, lane k (k = 0..3) uses phase `acc + k*F` modulo 2^24, where F is the held tuning word. After that clock the accumulator becomes `acc + 4*F` modulo 2^24.
- R3: Each valid lane sample equals round(8191 * sin(2*pi*phase/2^24)) within 3 LSB. Samples are 14-bit two's complement, and lane k sits at `smp_o[14k+13:14k]`.
- R4: No sample ever lies outside the range -8191..+8191. The code -8192 never appears.
- R5: The four valid bits of `vld_o` (bit k belongs to lane k) are always equal. A sample set sampled with `en` high at a rising edge appears on the outputs after the 19th rising edge, counting that edge as the first. That is 3 + 16 rotation stages.
- R6: In a clock where `en` is low, the accumulator holds and no sample set is produced for that clock.
- R7: `ftw_ld` high at a rising edge captures `ftw_in`. A sample set taken at that same edge still uses the previous word, and the next enabled edge uses the new word. A load with `en` low still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the accumulator and issue a sample set |
| ftw_ld | input | 1 | Load strobe for the tuning word |
| ftw_in | input | 24 | New frequency tuning word |
| smp_o | output | 56 | Four signed 14-bit samples, lane 0 in the low bits |
| vld_o | output | 4 | Valid flag per lane |

## Verification
A wrong accumulator step or a wrong lane offset shows up as a wrong sample value on some lane. It is visible 19 clocks after the faulty phase was issued, and every later set carries the error too, because the phase never recovers. A fault in quadrant folding or sign restoration flips or swaps whole quarter-waves, so the bench drives quarter and eighth steps and irregular words to cover all four quadrants. A broken valid pipeline or latency is caught as a missing or unexpected valid against the expected arrival cycle of each queued sample set.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // angle resolution used inside the rotators: one full turn = 2**ANG_W
    localparam int ANG_W = 26;

    // rotator gain after many micro-rotations (product of cos(atan(2^-i)))
    localparam real ROT_GAIN = 0.6072529350;

    // arctangent of 2^-i expressed in units of one turn / 2**ANG_W
    function automatic int atan_step(input int i);
        case (i)
            0:  atan_step = 8388608;
            1:  atan_step = 4952085;
            2:  atan_step = 2616545;
            3:  atan_step = 1328199;
            4:  atan_step = 666677;
            5:  atan_step = 333664;
            6:  atan_step = 166872;
            7:  atan_step = 83441;
            8:  atan_step = 41721;
            9:  atan_step = 20861;
            10: atan_step = 10430;
            11: atan_step = 5215;
            12: atan_step = 2608;
            13: atan_step = 1304;
            14: atan_step = 652;
            15: atan_step = 326;
            default: atan_step = 10680707 >>> i;
        endcase
    endfunction

endpackage

// File: rtl/dds_addsub.sv
module dds_addsub #(
    parameter int W = 20
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic                sub_i,
    output logic signed [W-1:0] y_o
);
    // one adder whose second operand is conditionally negated
    logic signed [W-1:0] b_eff;
    assign b_eff = sub_i ? ~b_i : b_i;
    assign y_o   = a_i + b_eff + W'(sub_i);
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PW    = 24,
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  srst,
    input  logic                  en,
    input  logic                  ld,
    input  logic [PW-1:0]         ftw_i,
    output logic [LANES*PW-1:0]   ph_o,
    output logic                  vld_o
);
    logic [PW-1:0] ftw_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] step;
    logic [PW-1:0] lane_ph [LANES];

    assign step = PW'(ftw_q * PW'(LANES));

    // parallel lane offsets: every lane has its own adder off the accumulator
    for (genvar k = 0; k < LANES; k++) begin : g_off
        assign lane_ph[k] = acc_q + PW'(ftw_q * PW'(k));
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            ftw_q <= '0;
            acc_q <= '0;
            vld_o <= 1'b0;
            ph_o  <= '0;
        end else begin
            if (ld) ftw_q <= ftw_i;
            if (en) begin
                acc_q <= acc_q + step;
                for (int k = 0; k < LANES; k++) ph_o[k*PW +: PW] <= lane_ph[k];
            end
            vld_o <= en;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (srst)
        $fell(srst) |-> (acc_q == '0 && ftw_q == '0 && !vld_o));

    assert_acc_advance_R2: assert property (@(posedge clk) disable iff (srst)
        ($past(en) && !$past(srst)) |-> acc_q == PW'($past(acc_q) + PW'($past(ftw_q) * PW'(LANES))));

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (srst)
        (!$past(en) && !$past(srst)) |-> ($stable(acc_q) && !vld_o));

    assert_load_word_R7: assert property (@(posedge clk) disable iff (srst)
        ($past(ld) && !$past(srst)) |-> ftw_q == $past(ftw_i));
endmodule

// File: rtl/dds_cordic_stage.sv
module dds_cordic_stage #(
    parameter int DW  = 20,
    parameter int ZW  = 27,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic                 vld_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic [1:0]           q_i,
    output logic                 vld_o,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [ZW-1:0] z_o,
    output logic [1:0]           q_o
);
    logic                 ccw;
    logic signed [DW-1:0] x_sh, y_sh, x_nx, y_nx;
    logic signed [ZW-1:0] ang, z_nx;

    assign ccw  = ~z_i[ZW-1];          // residual angle non-negative
    assign x_sh = x_i >>> IDX;
    assign y_sh = y_i >>> IDX;
    assign ang  = ZW'(dds_pkg::atan_step(IDX));

    dds_addsub #(.W(DW)) u_x (.a_i(x_i), .b_i(y_sh), .sub_i(ccw),  .y_o(x_nx));
    dds_addsub #(.W(DW)) u_y (.a_i(y_i), .b_i(x_sh), .sub_i(~ccw), .y_o(y_nx));
    dds_addsub #(.W(ZW)) u_z (.a_i(z_i), .b_i(ang),  .sub_i(ccw),  .y_o(z_nx));

    always_ff @(posedge clk) begin
        if (srst) vld_o <= 1'b0;
        else      vld_o <= vld_i;
        x_o <= x_nx;
        y_o <= y_nx;
        z_o <= z_nx;
        q_o <= q_i;
    end
endmodule

// File: rtl/dds_lane.sv
module dds_lane #(
    parameter int PW    = 24,
    parameter int AW    = 14,
    parameter int ITER  = 16,
    parameter int GUARD = 4
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic                 vld_i,
    input  logic [PW-1:0]        ph_i,
    output logic                 vld_o,
    output logic signed [AW-1:0] smp_o
);
    localparam int DW      = AW + GUARD + 2;
    localparam int ZW      = dds_pkg::ANG_W + 1;
    localparam int ZSH     = dds_pkg::ANG_W - PW;   // PW must stay below ANG_W + 1
    localparam int AMP_MAX = 2 ** (AW - 1) - 1;
    localparam int X_INIT  = int'(dds_pkg::ROT_GAIN * real'(AMP_MAX * (2 ** GUARD)));
    localparam logic signed [DW-1:0] LIM  = DW'(AMP_MAX);
    localparam logic signed [DW-1:0] HALF = DW'(2 ** (GUARD - 1));
    localparam logic signed [ZW-1:0] ZTOL = ZW'(2 * dds_pkg::atan_step(ITER - 1) + 4);

    // fold stage registers
    logic                 v_f;
    logic signed [DW-1:0] x_f;
    logic signed [ZW-1:0] z_f;
    logic [1:0]           q_f;
    logic signed [ZW-1:0] z_init;

    assign z_init = ZW'(ph_i[PW-3:0]) <<< ZSH;

    always_ff @(posedge clk) begin
        if (srst) v_f <= 1'b0;
        else      v_f <= vld_i;
        x_f <= DW'(X_INIT);
        z_f <= z_init;
        q_f <= ph_i[PW-1 -: 2];
    end

    // rotation chain
    logic                 vs [ITER+1];
    logic signed [DW-1:0] xs [ITER+1];
    logic signed [DW-1:0] ys [ITER+1];
    logic signed [ZW-1:0] zs [ITER+1];
    logic [1:0]           qs [ITER+1];

    assign vs[0] = v_f;
    assign xs[0] = x_f;
    assign ys[0] = '0;
    assign zs[0] = z_f;
    assign qs[0] = q_f;

    for (genvar i = 0; i < ITER; i++) begin : g_rot
        dds_cordic_stage #(.DW(DW), .ZW(ZW), .IDX(i)) u_stage (
            .clk   (clk),
            .srst  (srst),
            .vld_i (vs[i]),
            .x_i   (xs[i]),
            .y_i   (ys[i]),
            .z_i   (zs[i]),
            .q_i   (qs[i]),
            .vld_o (vs[i+1]),
            .x_o   (xs[i+1]),
            .y_o   (ys[i+1]),
            .z_o   (zs[i+1]),
            .q_o   (qs[i+1])
        );
    end

    // quadrant restore, rounding, saturation
    logic signed [DW-1:0] pick, rnd, lim_v;
    logic signed [AW-1:0] mag, res;

    always_comb begin
        pick = qs[ITER][0] ? xs[ITER] : ys[ITER];
        rnd  = (pick + HALF) >>> GUARD;
        if (rnd > LIM)       lim_v = LIM;
        else if (rnd < -LIM) lim_v = -LIM;
        else                 lim_v = rnd;
        mag = AW'(lim_v);
        res = qs[ITER][1] ? -mag : mag;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            vld_o <= 1'b0;
            smp_o <= '0;
        end else begin
            vld_o <= vs[ITER];
            smp_o <= res;
        end
    end

    assert_amp_bound_R4: assert property (@(posedge clk) disable iff (srst)
        vld_o |-> (smp_o <= AW'(AMP_MAX) && smp_o >= -AW'(AMP_MAX)));

    assert_residual_small_R3: assert property (@(posedge clk) disable iff (srst)
        vs[ITER] |-> (zs[ITER] <= ZTOL && zs[ITER] >= -ZTOL));
endmodule

// File: rtl/dds_quad_cordic.sv
module dds_quad_cordic #(
    parameter int PHASE_W = 24,
    parameter int AMP_W   = 14,
    parameter int LANES   = 4,
    parameter int ITER    = 16,
    parameter int GUARD   = 4
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     en,
    input  logic                     ftw_ld,
    input  logic [PHASE_W-1:0]       ftw_in,
    output logic [LANES*AMP_W-1:0]   smp_o,
    output logic [LANES-1:0]         vld_o
);
    logic [LANES*PHASE_W-1:0] ph;
    logic                     ph_vld;

    dds_phase_acc #(.PW(PHASE_W), .LANES(LANES)) u_acc (
        .clk   (clk),
        .srst  (srst),
        .en    (en),
        .ld    (ftw_ld),
        .ftw_i (ftw_in),
        .ph_o  (ph),
        .vld_o (ph_vld)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dds_lane #(.PW(PHASE_W), .AW(AMP_W), .ITER(ITER), .GUARD(GUARD)) u_lane (
            .clk   (clk),
            .srst  (srst),
            .vld_i (ph_vld),
            .ph_i  (ph[k*PHASE_W +: PHASE_W]),
            .vld_o (vld_o[k]),
            .smp_o (smp_o[k*AMP_W +: AMP_W])
        );
    end

    assert_lanes_aligned_R5: assert property (@(posedge clk) disable iff (srst)
        (vld_o == '0) || (vld_o == '1));
endmodule

// File: tb/dds_quad_cordic_bench.sv
module dds_quad_cordic_bench;
    localparam int LAT = 19;
    localparam int TOL = 3;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        en = 1'b0;
    logic        ftw_ld = 1'b0;
    logic [23:0] ftw_in = '0;
    logic [55:0] smp_o;
    logic [3:0]  vld_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          due_q [$];
    int          exp_q [$];
    logic [23:0] ph_q  [$];

    logic [23:0] m_acc = '0;
    logic [23:0] m_ftw = '0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    dds_quad_cordic u_dds_quad_cordic (
        .clk(clk), .srst(srst), .en(en), .ftw_ld(ftw_ld),
        .ftw_in(ftw_in), .smp_o(smp_o), .vld_o(vld_o)
    );

    function automatic int sine_ref(input logic [23:0] p);
        real a;
        a = 2.0 * 3.14159265358979 * real'(p) / 16777216.0;
        return int'(8191.0 * $sin(a));
    endfunction

    // driver: one clock of stimulus, expected items pushed into the scoreboard
    task automatic drive(input bit e, input bit l, input logic [23:0] f);
        @(negedge clk);
        srst = 1'b0; en = e; ftw_ld = l; ftw_in = f;
        if (e) begin
            for (int k = 0; k < 4; k++) begin
                logic [23:0] p;
                p = m_acc + 24'(m_ftw * k);      // R2 lane phase ordering
                ph_q.push_back(p);
                exp_q.push_back(sine_ref(p));
            end
            due_q.push_back(cyc + LAT);
            m_acc = m_acc + 24'(m_ftw * 4);
        end
        if (l) m_ftw = f;
    endtask

    task automatic run(input int n, input bit e);
        for (int i = 0; i < n; i++) drive(e, 1'b0, '0);
    endtask

    task automatic check_reset_state();
        n_cmp++;
        if (vld_o !== 4'b0 || smp_o !== '0) begin
            n_bad++;
            $display("FAIL R1 reset state: actual vld=%b smp=%h expected vld=0 smp=0", vld_o, smp_o);
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!srst) begin
            while (due_q.size() > 0 && due_q[0] < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL R5 missing set: actual none at cycle %0d expected valid", due_q[0]);
                void'(due_q.pop_front());
                for (int k = 0; k < 4; k++) begin void'(exp_q.pop_front()); void'(ph_q.pop_front()); end
            end
            if (vld_o !== 4'b0 && vld_o !== 4'b1111) begin
                n_cmp++; n_bad++;
                $display("FAIL R5 lane valid skew: actual %b expected 0000 or 1111", vld_o);
            end
            if (vld_o[0] === 1'b1) begin
                if (due_q.size() == 0 || due_q[0] != cyc) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R6 unexpected valid at cycle %0d: actual 1 expected 0", cyc);
                end else begin
                    void'(due_q.pop_front());
                    for (int k = 0; k < 4; k++) begin
                        int act, ex, d;
                        logic [23:0] p;
                        act = int'($signed(smp_o[k*14 +: 14]));
                        ex  = exp_q.pop_front();
                        p   = ph_q.pop_front();
                        d   = act - ex;
                        n_cmp++;
                        if (d > TOL || d < -TOL) begin
                            n_bad++;
                            $display("FAIL R2/R3/R7 lane %0d phase %h: actual %0d expected %0d", k, p, act, ex);
                        end
                        n_cmp++;
                        if (act > 8191 || act < -8191) begin
                            n_bad++;
                            $display("FAIL R4 range lane %0d: actual %0d expected within +-8191", k, act);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();                          // R1 after power-up reset
        run(4, 1'b1);                                 // R1: word cleared, phase 0 -> zeros
        drive(1'b1, 1'b1, 24'h400000);                // R7: this set still uses old word
        run(8, 1'b1);                                 // quarter step: 0,+max,0,-max (R4)
        run(3, 1'b0);                                 // R6 gap
        run(4, 1'b1);
        drive(1'b1, 1'b1, 24'h123457);
        run(30, 1'b1);
        drive(1'b1, 1'b1, 24'h200000);               // eighth step
        run(8, 1'b1);
        drive(1'b1, 1'b1, 24'hFFFFFF);               // R2 wrap, backward rotation
        run(10, 1'b1);
        drive(1'b0, 1'b1, 24'h0ABCDE);               // R7 load while disabled
        run(20, 1'b1);
        run(LAT + 4, 1'b0);                           // drain
        @(negedge clk);
        srst = 1'b1; en = 1'b0; ftw_ld = 1'b0;
        m_acc = '0; m_ftw = '0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();                          // R1 mid-run reset
        run(3, 1'b1);                                 // R1: accumulator and word cleared
        drive(1'b1, 1'b1, 24'h3FFFFF);
        run(12, 1'b1);
        run(LAT + 4, 1'b0);
        n_cmp++;
        if (due_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 leftover sets: actual %0d expected 0", due_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule